// File: doc/BRIEF.md
# Retriggerable Two-Phase One-Shot Timer

This block is a synchronous pulse stretcher with two trigger inputs. A rising edge on `trig_a` or a falling edge on `trig_b` starts an output pulse, but only when the other input is at its enabling level and the active-low clear is released. Each pulse has two parts. First comes a short discharge phase of fixed length, during which `disch_o` is high and no new trigger is accepted. Then comes a charge phase whose length is the value on `period_i`, captured at the moment the trigger was taken. The output `q` is high for both phases. Its complement is on `q_n`.

A trigger that arrives during the charge phase restarts the sequence at the discharge phase and captures a fresh period, so the pulse grows longer. When the charge phase runs out, `q` falls and the block goes back to idle. Both trigger inputs may be asynchronous. Each passes through a two-flop synchroniser before its edge is detected.

Top module: `oneshot_timer`

## Requirements
- R1: A rising edge on `trig_a` while `trig_b` is high and `clear_n` is high starts a pulse.
- R2: A rising edge on `trig_a` while `trig_b` is low has no effect, and `q` stays low.
- R3: A falling edge on `trig_b` while `trig_a` is low and `clear_n` is high starts a pulse.
- R4: A falling edge on `trig_b` while `trig_a` is high has no effect, and `q` stays low.
- R5: `q` rises at the third rising clock edge after the trigger input changes: two synchroniser stages, then the edge compare.
- R6: After a trigger is accepted, `disch_o` is high for exactly DISCHARGE_CYCLES cycles, starting together with `q`. It is never high while `q` is low.
- R7: The charge phase lasts `period_i` cycles, with 0 treated as 1, using the value captured when the trigger was accepted. An untriggered pulse therefore spans DISCHARGE_CYCLES + max(P,1) cycles. Changes to `period_i` after acceptance have no effect on that pulse.
- R8: A trigger that arrives while `disch_o` is high is ignored, and the pulse length does not change.
- R9: A trigger during the charge phase restarts the discharge phase and captures a new period. `q` stays high throughout the restart.
- R10: `q_n` is always the inverse of `q`.
- R11: Driving `clear_n` low forces `q` and `disch_o` low at once, without waiting for a clock edge. Triggers that occur while `clear_n` is low are discarded.
- R12: `rst` is synchronous and active-high. It returns the block to idle with `q` low, `q_n` high and `disch_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_n | input | 1 | Active-low asynchronous clear and trigger inhibit |
| trig_a | input | 1 | Rising-edge trigger, enabled while trig_b is high |
| trig_b | input | 1 | Falling-edge trigger, enabled while trig_a is low |
| period_i | input | PERIOD_W | Charge-phase length in cycles, captured on trigger |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Inverse of q |
| disch_o | output | 1 | High during the discharge phase |

## Verification
The hardest cases to reach are the two retrigger windows. One is a trigger that lands inside the two-cycle discharge phase and must be dropped. The other is a trigger that lands in the charge phase and must restart the timer. Each input edge reaches the state machine exactly three clock edges after it is driven, so the stimulus schedules the second edge at a fixed cycle offset from the first. That puts the second acceptance attempt one cycle inside discharge, or two cycles into charge. The expected pulse and discharge lengths are then counted directly at the ports.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Phase of the one-shot sequence
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DISCH  = 2'd1,
        PH_CHARGE = 2'd2
    } phase_e;

    // Lane numbering of the trigger inputs inside the synchroniser bus
    localparam int unsigned LANE_A = 0;
    localparam int unsigned LANE_B = 1;
    localparam int unsigned LANES  = 2;

    // What the edge detector reports about both trigger lanes
    typedef struct packed {
        logic a_lvl;
        logic b_lvl;
        logic a_rise;
        logic b_fall;
    } trig_view_s;

    // A trigger is valid on an A rise gated by B high, or a B fall gated by A low
    function automatic logic trig_valid(trig_view_s v, logic enable);
        return enable & ((v.a_rise & v.b_lvl) | (v.b_fall & ~v.a_lvl));
    endfunction

    // Counter width large enough for both the discharge and the charge length
    function automatic int unsigned cnt_width(int unsigned pw, int unsigned d);
        int unsigned dw;
        dw = (d < 2) ? 1 : $clog2(d);
        return (pw > dw) ? pw : dw;
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw inputs
    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_i;
    end

    // Remaining stages form the metastability chain
    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/os_edge_detect.sv
module os_edge_detect
    import oneshot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lvl_i,
    output trig_view_s       view_o
);
    logic [LANES-1:0] prev_q;
    logic [LANES-1:0] rise;
    logic [LANES-1:0] fall;

    // Remember the previous synchronised level of every lane
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign rise[l] =  lvl_i[l] & ~prev_q[l];
            assign fall[l] = ~lvl_i[l] &  prev_q[l];
        end
    endgenerate

    always_comb begin
        view_o.a_lvl  = lvl_i[LANE_A];
        view_o.b_lvl  = lvl_i[LANE_B];
        view_o.a_rise = rise[LANE_A];
        view_o.b_fall = fall[LANE_B];
    end
endmodule

// File: rtl/os_phase_fsm.sv
module os_phase_fsm
    import oneshot_pkg::*;
#(
    parameter int unsigned DISCHARGE_CYCLES = 2,
    parameter int unsigned PERIOD_W         = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_n,
    input  logic                fire_i,
    input  logic [PERIOD_W-1:0] period_i,
    output phase_e              phase_o
);
    localparam int unsigned CW = cnt_width(PERIOD_W, DISCHARGE_CYCLES);
    localparam logic [CW-1:0] DISCH_LOAD = CW'(DISCHARGE_CYCLES - 1);

    phase_e              phase_q;
    logic [CW-1:0]       cnt_q;
    logic [PERIOD_W-1:0] per_q;
    logic [CW-1:0]       charge_load;

    // Charge length minus one; a zero period still gives one cycle
    assign charge_load = (per_q == '0) ? '0 : (CW'(per_q) - CW'(1));

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            per_q   <= '0;
        end else if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            per_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (fire_i) begin
                        phase_q <= PH_DISCH;
                        cnt_q   <= DISCH_LOAD;
                        per_q   <= period_i;
                    end
                end
                PH_DISCH: begin
                    // triggers are not looked at here
                    if (cnt_q == '0) begin
                        phase_q <= PH_CHARGE;
                        cnt_q   <= charge_load;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                PH_CHARGE: begin
                    if (fire_i) begin
                        phase_q <= PH_DISCH;
                        cnt_q   <= DISCH_LOAD;
                        per_q   <= period_i;
                    end else if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int unsigned DISCHARGE_CYCLES = 2,
    parameter int unsigned PERIOD_W         = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_n,
    input  logic                trig_a,
    input  logic                trig_b,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                q,
    output logic                q_n,
    output logic                disch_o
);
    logic [LANES-1:0] raw_lvl;
    logic [LANES-1:0] sync_lvl;
    trig_view_s       view;
    logic             fire;
    phase_e           phase;
    logic             in_charge;

    always_comb begin
        raw_lvl         = '0;
        raw_lvl[LANE_A] = trig_a;
        raw_lvl[LANE_B] = trig_b;
    end

    os_sync #(.WIDTH(LANES), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_lvl),
        .sync_o  (sync_lvl)
    );

    os_edge_detect edge_i (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (sync_lvl),
        .view_o (view)
    );

    // clear_n low inhibits every trigger
    assign fire = trig_valid(view, clear_n);

    os_phase_fsm #(
        .DISCHARGE_CYCLES (DISCHARGE_CYCLES),
        .PERIOD_W         (PERIOD_W)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .clear_n  (clear_n),
        .fire_i   (fire),
        .period_i (period_i),
        .phase_o  (phase)
    );

    assign q         = (phase != PH_IDLE);
    assign q_n       = ~q;
    assign disch_o   = (phase == PH_DISCH);
    assign in_charge = (phase == PH_CHARGE);
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
    parameter int unsigned DISCHARGE_CYCLES = 2
) (
    input logic clk,
    input logic rst,
    input logic clear_n,
    input logic q,
    input logic disch_o,
    input logic fire,
    input logic in_charge
);
    // consecutive discharge cycles seen before the current one
    logic [15:0] dis_run;
    always_ff @(posedge clk) begin
        if (rst || !disch_o) dis_run <= '0;
        else                 dis_run <= dis_run + 16'd1;
    end

    a_r6_disch_bounded: assert property (@(posedge clk) disable iff (rst)
        disch_o |-> (dis_run < 16'(DISCHARGE_CYCLES)));

    a_r6_disch_inside_pulse: assert property (@(posedge clk) disable iff (rst)
        !q |-> !disch_o);

    a_r6_disch_to_charge: assert property (@(posedge clk) disable iff (rst)
        ($fell(disch_o) && clear_n && $past(clear_n) && !$past(rst)) |-> q);

    a_r1_fire_starts: assert property (@(posedge clk) disable iff (rst)
        (fire && !disch_o) |=> (!clear_n || (q && disch_o)));

    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        (in_charge && fire) |=> (!clear_n || disch_o));

    a_r7_ends_from_charge: assert property (@(posedge clk) disable iff (rst)
        ($fell(q) && clear_n && $past(clear_n) && !$past(rst)) |-> $past(in_charge));

    a_r11_clear_forces_idle: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> (!q && !disch_o));
endmodule

bind oneshot_timer oneshot_timer_chk #(
    .DISCHARGE_CYCLES (DISCHARGE_CYCLES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .clear_n   (clear_n),
    .q         (q),
    .disch_o   (disch_o),
    .fire      (fire),
    .in_charge (in_charge)
);

// File: tb/oneshot_timer_tb_top.sv
`timescale 1ns/1ps
module oneshot_timer_tb_top;
    localparam int D = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear_n = 1'b1;
    logic       trig_a = 1'b0;
    logic       trig_b = 1'b1;
    logic [7:0] period_i = 8'd0;
    logic       q, q_n, disch_o;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    oneshot_timer #(.DISCHARGE_CYCLES(D), .PERIOD_W(8)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .clear_n  (clear_n),
        .trig_a   (trig_a),
        .trig_b   (trig_b),
        .period_i (period_i),
        .q        (q),
        .q_n      (q_n),
        .disch_o  (disch_o)
    );

    // use_b, other-input level, period, fires, expected q width
    typedef struct packed {
        logic       use_b;
        logic       other;
        logic [7:0] per;
        logic       fires;
        logic [7:0] width;
    } vec_t;

    localparam int NV = 7;
    localparam logic [18:0] VECS [NV] = '{
        {1'b0, 1'b1, 8'd5,  1'b1, 8'd7},
        {1'b0, 1'b0, 8'd5,  1'b0, 8'd0},
        {1'b1, 1'b0, 8'd3,  1'b1, 8'd5},
        {1'b1, 1'b1, 8'd3,  1'b0, 8'd0},
        {1'b0, 1'b1, 8'd0,  1'b1, 8'd3},
        {1'b1, 1'b0, 8'd1,  1'b1, 8'd3},
        {1'b0, 1'b1, 8'd12, 1'b1, 8'd14}
    };

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Set idle levels under clear so no edge is taken, then release
    task automatic prep(logic use_b, logic other, logic [7:0] per);
        @(negedge clk);
        clear_n = 1'b0;
        if (use_b) begin trig_a = other; trig_b = 1'b1; end
        else       begin trig_a = 1'b0;  trig_b = other; end
        period_i = per;
        repeat (4) @(negedge clk);
        clear_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic string tag_for(vec_t v);
        if (!v.use_b) return v.fires ? "R1" : "R2";
        return v.fires ? "R3" : "R4";
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        int hi, dis, first, qn_bad;

        repeat (5) @(negedge clk);
        // R12: reset state
        check("R12 q after reset", q, 0);
        check("R10 q_n after reset", q_n, 1);
        check("R12 disch after reset", disch_o, 0);
        rst = 1'b0;

        // Table walk: R1..R7, R10
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            prep(v.use_b, v.other, v.per);
            check("R11 idle after clear release", q, 0);
            if (v.use_b) trig_b = 1'b0; else trig_a = 1'b1;
            hi = 0; dis = 0; first = 0; qn_bad = 0;
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if (k == 4) period_i = ~v.per;  // R7: late change ignored
                if (q && first == 0) first = k;
                hi += int'(q);
                dis += int'(disch_o);
                if (q_n !== ~q) qn_bad++;
            end
            check(tag_for(v), hi, int'(v.width));
            check("R7 pulse width", hi, int'(v.width));
            check("R6 discharge length", dis, v.fires ? D : 0);
            if (v.fires) check("R5 latency", first, 3);
            check("R10 q_n inverse", qn_bad, 0);
        end

        // R8: second A rise accepted-attempt lands inside discharge
        prep(1'b0, 1'b1, 8'd4);
        trig_a = 1'b1;
        hi = 0; dis = 0;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (k == 1) trig_a = 1'b0;
            if (k == 2) trig_a = 1'b1;
            hi += int'(q);
            dis += int'(disch_o);
        end
        check("R8 width unchanged", hi, D + 4);
        check("R8 single discharge", dis, D);

        // R9: retrigger during charge, new period 3
        prep(1'b0, 1'b1, 8'd6);
        trig_a = 1'b1;
        hi = 0; dis = 0; qn_bad = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 3) trig_a = 1'b0;
            if (k == 4) period_i = 8'd3;
            if (k == 5) trig_a = 1'b1;
            if (k > 3 && k < 13 && !q) qn_bad++;
            hi += int'(q);
            dis += int'(disch_o);
        end
        check("R9 stretched width", hi, 5 + D + 3);
        check("R9 two discharges", dis, 2 * D);
        check("R9 q held through restart", qn_bad, 0);

        // R11: asynchronous clear mid-pulse and trigger inhibit
        prep(1'b0, 1'b1, 8'd20);
        trig_a = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 pulse running", q, 1);
        clear_n = 1'b0;
        #1;
        check("R11 q dropped without clock", q, 0);
        check("R11 disch dropped", disch_o, 0);
        check("R10 q_n on clear", q_n, 1);
        @(negedge clk);
        trig_a = 1'b0;
        repeat (3) @(negedge clk);
        trig_a = 1'b1;
        hi = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            hi += int'(q);
        end
        clear_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            hi += int'(q);
        end
        check("R11 trigger under clear discarded", hi, 0);

        // R12: synchronous reset mid-pulse
        prep(1'b0, 1'b1, 8'd20);
        trig_a = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        trig_a = 1'b0;
        #1;
        check("R12 reset is synchronous", q, 1);
        @(negedge clk);
        check("R12 q after reset", q, 0);
        check("R12 q_n after reset", q_n, 1);
        check("R12 disch after reset", disch_o, 0);
        rst = 1'b0;
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            hi += int'(q);
        end
        check("R12 stays idle", hi, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule